// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a synchronous monostable. It drives a single output pulse high for a programmed number of clock cycles when its gated trigger inputs reach an active combination. There are two trigger inputs: `trig_a_n` is active low and `trig_b` is active high. An active-low clear input, `clr_n`, forces the pulse to end at once. The pulse length is taken from the `dur` input. It replaces the resistor and capacitor that set the time of an analog one-shot.

A start is qualified by levels at the moment an edge is seen. There are three ways to start a pulse:
- `trig_b` rises while `trig_a_n` is low.
- `trig_a_n` falls while `trig_b` is high.
- `clr_n` is released while `trig_a_n` is low and `trig_b` is high.

Every input passes through a synchronizer, and edges are found by comparing each synchronized sample with the one before it. A qualifying edge that arrives during a pulse reloads the count, so the pulse grows longer. The complementary output `q_n` always mirrors `q`.

Top module: `retrig_oneshot`

## Requirements
- R1: While reset is asserted, and after it is released with no trigger, `q` is 0 and `q_n` is 1.
- R2: A 0-to-1 change of `trig_b` while `trig_a_n` is 0 and `clr_n` is 1 starts a pulse.
- R3: A 1-to-0 change of `trig_a_n` while `trig_b` is 1 and `clr_n` is 1 starts a pulse.
- R4: A 0-to-1 change of `clr_n` while `trig_a_n` is 0 and `trig_b` is 1 starts a pulse.
- R5: Edges that happen with the other trigger input at its inactive level start nothing. Examples are `trig_b` rising while `trig_a_n` is 1, and `trig_a_n` falling while `trig_b` is 0.
- R6: A qualifying edge during a pulse reloads the count. The pulse then ends `dur` cycles after that retrigger instead of after the first trigger.
- R7: Driving `clr_n` to 0 ends an active pulse. `q` is 0 from the third rising clock edge after the change.
- R8: While `clr_n` is 0, activity on `trig_a_n` and `trig_b` starts no pulse.
- R9: The length of a pulse, in clock cycles, equals the `dur` value captured at its trigger. Changes to `dur` after the trigger do not alter that pulse.
- R10: A trigger captured with `dur` equal to 0 produces no pulse. If it arrives as a retrigger, it ends the pulse in progress.
- R11: `q_n` is the inverse of `q` on every cycle.
- R12: `q` rises on the third rising clock edge after a qualifying input change, with the default two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Active-low trigger input |
| trig_b | input | 1 | Active-high trigger input |
| clr_n | input | 1 | Active-low clear; overrides both triggers |
| dur | input | WIDTH | Pulse length in clock cycles, captured at each trigger |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
Some properties are checked on every cycle:
- `q_n` is the complement of `q`.
- `q` stays low during reset.
- A clear held at the port for three cycles forces `q` low.
- `q` never rises unless the clear was high and the captured duration was nonzero.

Other behaviours only the directed scenarios can show:
- Which edge combinations start a pulse.
- The exact pulse length.
- The longer pulse produced by a retrigger.
- That a duration change after the trigger has no effect.
- The three-edge start latency.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   // Synchronized control inputs, kept together so one synchronizer serves all three.
   typedef struct packed {
      logic clr_n;
      logic a_n;
      logic b;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Quiet levels: clear released, A inactive high, B inactive low.
   localparam logic [CTL_W-1:0] CTL_QUIET = 3'b110;

   // A start needs the gate open now (clear high, A low, B high)
   // and at least one of the three signals to have just moved into that state.
   function automatic logic start_seen(input ctl_t now_s, input ctl_t old_s);
      logic gate_open;
      logic moved;
      gate_open = now_s.clr_n & ~now_s.a_n & now_s.b;
      moved     = (now_s.b & ~old_s.b)
                | (~now_s.a_n & old_s.a_n)
                | (now_s.clr_n & ~old_s.clr_n);
      return gate_open & moved;
   endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
   parameter int               W      = 3,
   parameter int               STAGES = 2,
   parameter logic [W-1:0]     RST_V  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (STAGES < 2) $error("oneshot_sync: STAGES must be at least 2");
      if (W < 1)      $error("oneshot_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_V;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_V;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
   import oneshot_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  ctl_t smp,
   output logic fire,
   output logic clr_hold
);

   // Edges are ignored until the synchronizer has flushed its reset value,
   // so a non-quiet input level at reset release does not look like an edge.
   localparam int ARM_CYC = STAGES + 1;
   localparam int ARM_W   = $clog2(ARM_CYC + 1);
   localparam logic [ARM_W-1:0] ARM_END = ARM_W'(ARM_CYC);

   logic [ARM_W-1:0] arm_cnt;
   logic             armed;
   ctl_t             prev;

   assign armed = (arm_cnt == ARM_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_cnt <= '0;
      else if (!armed) arm_cnt <= arm_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= ctl_t'(CTL_QUIET);
      else        prev <= smp;
   end

   assign fire     = armed & start_seen(smp, prev);
   assign clr_hold = ~smp.clr_n;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             clr_hold,
   input  logic [WIDTH-1:0] dur,
   output logic             q
);

   logic [WIDTH-1:0] cnt;
   logic [WIDTH-1:0] cnt_nxt;

   // Clear wins over everything; a trigger reloads; otherwise count down to zero.
   always_comb begin
      cnt_nxt = cnt;
      if (clr_hold)        cnt_nxt = '0;
      else if (fire)       cnt_nxt = dur;
      else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   generate
      if (OUT_REG) begin : g_qreg
         // Dedicated output flop: the pulse edge comes straight from a register.
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= (cnt_nxt != '0);
         end
         assign q = q_r;
      end else begin : g_qdec
         assign q = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
   import oneshot_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_a_n,
   input  logic             trig_b,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] dur,
   output logic             q,
   output logic             q_n
);

   initial begin
      if (WIDTH < 1 || WIDTH > 32) $error("retrig_oneshot: WIDTH out of range");
      if (SYNC_STAGES < 2)         $error("retrig_oneshot: SYNC_STAGES below 2");
   end

   ctl_t             raw;
   logic [CTL_W-1:0] smp_bits;
   ctl_t             smp;
   logic             fire;
   logic             clr_hold;

   assign raw = '{clr_n: clr_n, a_n: trig_a_n, b: trig_b};

   oneshot_sync #(
      .W      (CTL_W),
      .STAGES (SYNC_STAGES),
      .RST_V  (CTL_QUIET)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (smp_bits)
   );

   assign smp = ctl_t'(smp_bits);

   oneshot_edge #(
      .STAGES (SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .fire     (fire),
      .clr_hold (clr_hold)
   );

   oneshot_timer #(
      .WIDTH   (WIDTH),
      .OUT_REG (OUT_REG)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .clr_hold (clr_hold),
      .dur      (dur),
      .q        (q)
   );

   assign q_n = ~q;

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_n,
   input logic [WIDTH-1:0] dur,
   input logic             q,
   input logic             q_n
);

   // R11
   complement_chk: assert property (@(posedge clk) disable iff (!rst_n) q_n == ~q);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_low_chk: assert (q == 1'b0 && q_n == 1'b1);
      end
   end

   // R7
   clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> ##3 !q);

   // R8
   rise_needs_clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(clr_n, 3));

   // R10
   rise_needs_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(dur) != '0);

endmodule

bind retrig_oneshot oneshot_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .clr_n (clr_n),
   .dur   (dur),
   .q     (q),
   .q_n   (q_n)
);

// File: tb/retrig_oneshot_test.sv
module retrig_oneshot_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trig_a_n = 1'b1;
   logic         trig_b = 1'b0;
   logic         clr_n = 1'b1;
   logic [W-1:0] dur = '0;
   logic         q;
   logic         q_n;

   int n_tests = 0;
   int n_fail  = 0;
   int qn_bad  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   retrig_oneshot #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b(trig_b),
      .clr_n(clr_n), .dur(dur), .q(q), .q_n(q_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Sample on falling edges; index i is the state after the i-th rising edge.
   task automatic observe(input int win, output int hi, output int first);
      hi = 0; first = 0;
      for (int i = 1; i <= win; i++) begin
         @(negedge clk);
         if (q_n !== ~q) qn_bad++;
         if (q === 1'b1) begin
            hi++;
            if (first == 0) first = i;
         end
      end
   endtask

   task automatic go_quiet();
      @(negedge clk);
      trig_a_n = 1'b1; trig_b = 1'b0; clr_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 q in reset", int'(q), 0);
      check("R1 q_n in reset", int'(q_n), 1);
      @(negedge clk); rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R1 q after reset", int'(q), 0);
      check("R1 q_n after reset", int'(q_n), 1);
   endtask

   task automatic t_b_rise();
      int hi, first;
      @(negedge clk); dur = 8'd7; trig_a_n = 1'b0;   // A falls with B low
      observe(8, hi, first);
      check("R5 A fall with B low", hi, 0);
      trig_b = 1'b1;                                  // drive at the negedge just sampled
      observe(20, hi, first);
      check("R2 B rise length", hi, 7);
      check("R12 start latency", first, 3);
      go_quiet();
   endtask

   task automatic t_a_fall();
      int hi, first;
      @(negedge clk); dur = 8'd5; trig_b = 1'b1;     // B rises with A high
      observe(8, hi, first);
      check("R5 B rise with A high", hi, 0);
      trig_a_n = 1'b0;
      observe(16, hi, first);
      check("R3 A fall length", hi, 5);
      check("R3 A fall latency", first, 3);
   endtask

   task automatic t_clear_release();
      int hi, first;
      @(negedge clk); dur = 8'd4; clr_n = 1'b0;      // A low, B high held
      observe(6, hi, first);
      check("R8 no pulse during clear", hi, 0);
      clr_n = 1'b1;
      observe(14, hi, first);
      check("R4 clear release length", hi, 4);
      go_quiet();
   endtask

   task automatic t_retrigger();
      int hi = 0;
      @(negedge clk); dur = 8'd10; trig_a_n = 1'b0;
      repeat (4) @(negedge clk);
      trig_b = 1'b1;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (q === 1'b1) hi++;
         if (i == 4) trig_b = 1'b0;
         if (i == 6) trig_b = 1'b1;
      end
      check("R6 retrigger length", hi, 16);
      go_quiet();
   endtask

   task automatic t_clear_cut();
      int hi = 0, last = 0, hi_clr = 0;
      @(negedge clk); dur = 8'd20; trig_a_n = 1'b0;
      repeat (4) @(negedge clk);
      trig_b = 1'b1;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (q === 1'b1) begin hi++; last = i; end
         if (i == 6) clr_n = 1'b0;
      end
      check("R7 clear cut length", hi, 6);
      check("R7 clear cut last high", last, 8);
      for (int i = 1; i <= 16; i++) begin
         @(negedge clk);
         if (q === 1'b1) hi_clr++;
         case (i)
            2:  trig_b   = 1'b0;
            4:  trig_b   = 1'b1;
            6:  trig_a_n = 1'b1;
            8:  trig_a_n = 1'b0;
            default: ;
         endcase
      end
      check("R8 triggers ignored in clear", hi_clr, 0);
      go_quiet();
   endtask

   task automatic t_dur_capture();
      int hi, first;
      @(negedge clk); dur = 8'd6; trig_a_n = 1'b0;
      repeat (4) @(negedge clk);
      trig_b = 1'b1;
      observe(4, hi, first);
      dur = 8'd30;
      begin
         int hi2, f2;
         observe(40, hi2, f2);
         check("R9 captured length", hi + hi2, 6);
      end
      go_quiet();
   endtask

   task automatic t_zero();
      int hi, first;
      @(negedge clk); dur = 8'd0; trig_a_n = 1'b0;
      repeat (4) @(negedge clk);
      trig_b = 1'b1;
      observe(12, hi, first);
      check("R10 zero length", hi, 0);
      go_quiet();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_b_rise();
      t_a_fall();
      t_clear_release();
      t_retrigger();
      t_clear_cut();
      t_dur_capture();
      t_zero();
      check("R11 q_n complement", qn_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule